// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that controls a 16-bit port of quasi-bidirectional pins. Each pin has one latch bit. A 0 in the latch pulls the pin low. A 1 releases the pin to its weak pull-up, and the pin can then be read as an input. There is no separate direction register: software turns a pin into an input by writing a 1 to its latch bit.

A write transaction loads the latch, two bytes at a time. A read transaction returns the levels that the pins actually have. It does not return the latch contents, so a pin held low by its own latch reads 0 in the same way as a pin that something outside holds low.

SCL and SDA enter as levels sampled on the system clock. The target pulls SDA low by asserting `sda_pull_o`. The pin side is a level input bus and a pull-low enable bus, which are meant to drive open-drain pads.

Top module: `qbx_expander`

## Requirements
- R1: After reset the latch holds all ones, so `pin_pull_o` is all zeros and `sda_pull_o` is low.
- R2: The target pulls SDA low during the acknowledge slot that follows an address byte whose upper 7 bits equal the `TGT_ADDR` parameter. On a mismatch it sends no acknowledge and keeps SDA released until the next START.
- R3: In a write, the first data byte sets latch bits 7:0 and the second sets bits 15:8. `pin_pull_o` equals the bitwise inverse of the latch.
- R4: The latch changes only after the second byte of a pair has been acknowledged. A write that stops after a single data byte leaves the latch unchanged.
- R5: A read (address bit 0 equal to 1) returns the sampled pin levels: bits 7:0 first, then bits 15:8, each byte MSB first. A pin that its latch holds low reads 0.
- R6: The pin levels are captured once, when the read address is acknowledged. Both bytes come from that capture, even if the pins change during the transfer.
- R7: In a write longer than two bytes, the bytes keep alternating low, high, low, high. Every complete pair updates the latch, and a trailing unpaired byte is discarded.
- R8: In a read longer than two bytes, the bytes keep alternating low and high from the same capture until the controller sends a NACK.
- R9: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START without a STOP begins a new address phase.
- R10: SDA is pulled low only in acknowledge slots the target owns and in read data bits whose value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample SCL and SDA |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| sda_pull_o | output | 1 | High to pull SDA low |
| pin_i | input | PORT_W | Sampled levels of the port pins |
| pin_pull_o | output | PORT_W | High to pull the matching pin low |

## Verification
The assertions assume a controller that changes SDA only while SCL is low, except at START and STOP. They also assume that every SCL phase lasts several system clocks, longer than the two-flop synchronizer delay. The bench keeps SCL low and high phases ten clocks long and moves SDA in the middle of the low phase. It models each pin as the external level ANDed with the inverse of `pin_pull_o`, which is how a weak pull-up behaves. Random latch values and random pin levels are checked against a model of the latch and pin levels that the bench keeps itself.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } qbx_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
  import qbx_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h27,
  parameter int NBYTES = 2,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl,
  input  logic             sda,
  input  logic [7:0]       rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             snap_en,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  qbx_state_e       state;
  logic             scl_q, sda_q, rise, fall, start_det, stop_det;
  logic [3:0]       cnt;
  logic [7:0]       sr, tx;
  logic             rw;
  logic [IDX_W-1:0] idx, idx_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign rise      = scl & ~scl_q;
  assign fall      = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign idx_nx    = (idx == IDX_W'(NBYTES - 1)) ? '0 : idx + 1'b1;
  assign rd_idx    = idx;
  assign wr_data   = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sr       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      idx      <= '0;
      sda_pull <= 1'b0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      snap_en  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      snap_en  <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        idx      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (rise) begin
              sr  <= {sr[6:0], sda};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == 4'd8) begin
              if (state == ST_WDAT) begin
                sda_pull <= 1'b1;
                state    <= ST_WACK;
              end else if (sr[7:1] == TGT_ADDR) begin
                rw       <= sr[0];
                snap_en  <= sr[0];
                sda_pull <= 1'b1;
                state    <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: if (fall) begin
            cnt <= '0;
            if (rw) begin
              state    <= ST_RDAT;
              tx       <= rd_byte;
              sda_pull <= ~rd_byte[7];
            end else begin
              state    <= ST_WDAT;
              sda_pull <= 1'b0;
            end
          end
          ST_WACK: if (fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            wr_valid <= 1'b1;
            wr_idx   <= idx;
            idx      <= idx_nx;
            state    <= ST_WDAT;
          end
          ST_RDAT: begin
            if (rise) cnt <= cnt + 1'b1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= ST_RACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (rise) begin
              if (sda) state <= ST_SKIP;
              else     idx   <= idx_nx;
            end else if (fall) begin
              cnt      <= '0;
              tx       <= rd_byte;
              sda_pull <= ~rd_byte[7];
              state    <= ST_RDAT;
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end

  // R10
  sda_owner_chk: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (state == ST_AACK || state == ST_WACK || state == ST_RDAT));
  // R2
  skip_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_pull);
  // R9
  start_addr_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_pull));
endmodule

// File: rtl/qbx_port.sv
module qbx_port #(
  parameter int PORT_W = 16,
  localparam int NBYTES = PORT_W / 8,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins,
  input  logic              snap_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_byte,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [PORT_W-1:0] drive_low
);
  logic [PORT_W-1:0] stage, stage_nx, snap_q;
  logic [7:0]        snap_bytes [NBYTES];
  logic              commit;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign stage_nx[b*8 +: 8] = (wr_idx == IDX_W'(b)) ? wr_data : stage[b*8 +: 8];
    assign snap_bytes[b]      = snap_q[b*8 +: 8];
  end

  assign commit  = wr_valid && (wr_idx == IDX_W'(NBYTES - 1));
  assign rd_byte = snap_bytes[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage     <= '1;
      drive_low <= '0;
      snap_q    <= '0;
    end else begin
      if (wr_valid) stage     <= stage_nx;
      if (commit)   drive_low <= ~stage_nx;
      if (snap_en)  snap_q    <= pins;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (drive_low == '0));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(drive_low));
  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !snap_en |=> $stable(snap_q));
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander #(
  parameter int PORT_W = 16,
  parameter logic [6:0] TGT_ADDR = 7'h27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_pull_o
);
  localparam int NBYTES = PORT_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [1:0]        bus_s;
  logic [PORT_W-1:0] pins_s;
  logic              snap_en, wr_valid;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [7:0]        rd_byte, wr_data;

  qbx_sync #(.W(2), .RST_VAL(2'b11)) bus_sync_i (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s));

  qbx_sync #(.W(PORT_W), .RST_VAL('1)) pin_sync_i (
    .clk(clk), .rst(rst), .d(pin_i), .q(pins_s));

  qbx_i2c_target #(.TGT_ADDR(TGT_ADDR), .NBYTES(NBYTES)) target_i (
    .clk(clk), .rst(rst), .scl(bus_s[1]), .sda(bus_s[0]),
    .rd_byte(rd_byte), .rd_idx(rd_idx), .snap_en(snap_en),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_pull(sda_pull_o));

  qbx_port #(.PORT_W(PORT_W)) port_i (
    .clk(clk), .rst(rst), .pins(pins_s), .snap_en(snap_en),
    .rd_idx(rd_idx), .rd_byte(rd_byte), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data), .drive_low(pin_pull_o));
endmodule

// File: tb/qbx_expander_tb.sv
module qbx_expander_tb_top;
  localparam logic [6:0] ADR = 7'h27;
  localparam int Q = 5;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, sda_bus;
  logic [15:0] ext = 16'hFFFF, pull, pins;
  logic [15:0] latch_m = 16'hFFFF;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;
  assign pins    = ext & ~pull;

  qbx_expander #(.PORT_W(16), .TGT_ADDR(ADR)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .pin_i(pins), .pin_pull_o(pull));

  function automatic logic [15:0] exp_read(logic [15:0] e, logic [15:0] l);
    return e & l;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(2*Q); sda_m = 1'b0; wq(2*Q); scl = 1'b0;
  endtask
  task automatic i2c_stop;
    wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b1; wq(2*Q); sda_m = 1'b1; wq(2*Q);
  endtask
  task automatic put_bit(logic b);
    wq(Q); sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0;
  endtask
  task automatic get_bit(output logic b);
    wq(Q); sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0;
  endtask
  task automatic put_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask
  task automatic get_byte(logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(nack);
  endtask

  task automatic wr_pair(logic [15:0] v);
    logic a;
    i2c_start; put_byte({ADR, 1'b0}, a); chk("R2 addr ack", 16'(a), 16'h0);
    put_byte(v[7:0], a); put_byte(v[15:8], a); i2c_stop;
    latch_m = v;
  endtask
  task automatic rd_pair(output logic [15:0] v);
    logic a;
    i2c_start; put_byte({ADR, 1'b1}, a);
    get_byte(1'b0, v[7:0]); get_byte(1'b1, v[15:8]); i2c_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, e;
    logic a;
    logic [7:0] b0, b1, b2, b3;
    wq(10); rst = 1'b0; wq(4);
    chk("R1 pull after reset", pull, 16'h0000);
    chk("R1 sda after reset", 16'(sda_pull), 16'h0);

    ext = 16'hA5C3; rd_pair(r); chk("R5 read released pins", r, 16'hA5C3);

    wr_pair(16'h1234); wq(4);
    chk("R3 byte order to pull", pull, ~16'h1234);
    ext = 16'hFFFF; rd_pair(r); chk("R5 driven low reads 0", r, 16'h1234);

    i2c_start; put_byte({ADR, 1'b0}, a); put_byte(8'h00, a); i2c_stop; wq(4);
    chk("R4 single byte no change", pull, ~latch_m);

    i2c_start; put_byte({ADR ^ 7'h01, 1'b0}, a);
    chk("R2 mismatch nack", 16'(a), 16'h1);
    put_byte(8'h00, a); chk("R2 mismatch released", 16'(a), 16'h1);
    put_byte(8'h00, a); i2c_stop; wq(4);
    chk("R2 mismatch latch", pull, ~latch_m);

    i2c_start; put_byte({ADR, 1'b0}, a);
    put_byte(8'hAA, a); put_byte(8'h55, a); put_byte(8'h00, a); i2c_stop; wq(4);
    latch_m = 16'h55AA; chk("R7 odd byte dropped", pull, ~latch_m);
    i2c_start; put_byte({ADR, 1'b0}, a);
    put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a); put_byte(8'h44, a);
    i2c_stop; wq(4);
    latch_m = 16'h4433; chk("R7 second pair", pull, ~latch_m);

    wr_pair(16'hFFFF); ext = 16'h0F0F;
    i2c_start; put_byte({ADR, 1'b1}, a);
    get_byte(1'b0, b0); ext = 16'hF0F0; get_byte(1'b1, b1); i2c_stop;
    chk("R6 snapshot low", {8'h0, b0}, 16'h000F);
    chk("R6 snapshot high", {8'h0, b1}, 16'h000F);

    ext = 16'h9C36;
    i2c_start; put_byte({ADR, 1'b1}, a);
    get_byte(1'b0, b0); get_byte(1'b0, b1); get_byte(1'b0, b2); get_byte(1'b1, b3);
    i2c_stop;
    chk("R8 repeat low", {b2, b0}, 16'h3636);
    chk("R8 repeat high", {b3, b1}, 16'h9C9C);

    ext = 16'hFFFF;
    i2c_start; put_byte({ADR, 1'b0}, a); put_byte(8'h5A, a); put_byte(8'hC3, a);
    latch_m = 16'hC35A;
    i2c_start; put_byte({ADR, 1'b1}, a); chk("R9 restart ack", 16'(a), 16'h0);
    get_byte(1'b0, b0); get_byte(1'b1, b1); i2c_stop;
    chk("R9 restart read", {b1, b0}, latch_m);

    void'($urandom(32'd1234));
    for (int k = 0; k < 30; k++) begin
      e = 16'($urandom());
      wr_pair(16'($urandom())); ext = e; wq(4);
      chk("R3 random pull", pull, ~latch_m);
      rd_pair(r); chk("R5 random read", r, exp_read(e, latch_m));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule